// File: doc/BRIEF.md
# SPI Slave Byte Engine

This block is the receive/transmit core of an SPI slave. It exchanges 8-bit bytes, most significant bit first, with an external master, in either clock polarity and either clock phase. The serial clock, the data input and the active-low select are oversampled in the system clock domain. Each passes through a two-flop synchronizer, and all serial edges are found there, so the whole block runs on one clock. A parallel transmit byte is held in a register that the local logic writes with a load strobe. Each received byte comes out on a parallel port, together with a one-cycle completion pulse.

The phase setting changes how a byte is framed. With phase 0, the data line must already carry the MSB when the first clock edge arrives, so the falling edge of select starts every byte. Select then has to return high before the next byte can begin. With phase 1, the slave drives on the leading clock edge and samples on the trailing edge, and one select assertion may carry any number of bytes. A master-mode input turns the slave engine off and turns on a mode-fault detector. The detector raises a flag when select is pulled low while the block acts as a master.

The control state machine has three states. ST_IDLE is the deselected state. ST_SHIFT moves bits. ST_HOLD is used with phase 0 after a complete byte, while the block waits for select to go high. The transitions are:
- START: ST_IDLE to ST_SHIFT, on a falling select edge while not in master mode.
- FINISH: ST_SHIFT to ST_HOLD, on the 8th sampling edge with phase 0.
- WRAP: ST_SHIFT to ST_SHIFT, on the 8th sampling edge with phase 1.
- ABORT: ST_SHIFT to ST_IDLE, when select goes high or master mode is asserted.
- RELEASE: ST_HOLD to ST_IDLE, under the same conditions as ABORT.

Top module: `spis_slave_core`

## Requirements
- R1: `miso_o` is high-impedance and `miso_oe_o` is 0 whenever select is high or master mode is set. While the block is selected as a slave, `miso_o` is driven and `miso_oe_o` is 1.
- R2: With phase 0 (`cpha_i`=0), the falling edge of select presents the MSB of the held transmit byte on `miso_o` before the first clock edge. Each following bit is presented after a trailing clock edge.
- R3: With phase 0, once 8 bits have been received, further clock edges are ignored until select goes high. `rx_done_o` stays 0 and `rx_byte_o` keeps its value.
- R4: With phase 1 (`cpha_i`=1), bits are driven on leading edges and sampled on trailing edges. Consecutive bytes may be transferred within a single select assertion.
- R5: Bytes are 8 bits, MSB first in both directions. After the 8th sampling edge, `rx_byte_o` holds the received byte and `rx_done_o` pulses high for exactly one cycle.
- R6: `cpol_i`=0 gives a low idle clock with a rising leading edge. `cpol_i`=1 gives a high idle clock with a falling leading edge. The bit order is the same for both.
- R7: If select goes high before the 8th sampling edge, the partial byte is discarded and no `rx_done_o` pulse occurs. The next selected byte is received correctly.
- R8: A `tx_load_i` pulse stores `tx_byte_i`. The next byte transmitted uses the byte stored most recently.
- R9: While `master_mode_i`=1, a low select sets `mode_fault_o`. The flag stays set while master mode remains on and clears when `master_mode_i` returns to 0.
- R10: After reset, `rx_byte_o`=0, `rx_done_o`=0, `mode_fault_o`=0, and `miso_o` is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| sel_n_i | input | 1 | Active-low slave select |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| master_mode_i | input | 1 | Block acts as a master: slave engine off, fault detector on |
| tx_byte_i | input | 8 | Byte to transmit |
| tx_load_i | input | 1 | Store strobe for `tx_byte_i` |
| miso_o | output | 1 | Serial data to the master, high-impedance when not driven |
| miso_oe_o | output | 1 | Output enable of `miso_o` |
| rx_byte_o | output | 8 | Last complete received byte |
| rx_done_o | output | 1 | One-cycle pulse when a byte completes |
| mode_fault_o | output | 1 | Select was pulled low while in master mode |

## Verification
The hardest case to reach from the ports is the ST_HOLD state in phase 0, where the master keeps clocking after a full byte without releasing select. It is closely followed by an abort after a few bits. Directed sequences produce both cases. One sends 8 extra clock cycles with different data under the same select assertion. The other raises select after three bits. After each, the bench checks at the ports that neither the completion count nor the received byte has changed, and that a following normal byte is still correct. A seeded random mix of polarities, phases, byte values and burst lengths then alternates between the framing rules, so mode switches land between arbitrary bytes.

// File: rtl/spis_pkg.sv
package spis_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } spis_state_e;

    localparam int SIG_SCK  = 0;
    localparam int SIG_SEL  = 1;
    localparam int SIG_MOSI = 2;
    localparam int SIG_NUM  = 3;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] chg_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign chg_o = lvl_i ^ prev_q;
endmodule

// File: rtl/spis_modefault.sv
module spis_modefault (
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic sel_s_i,
    output logic fault_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fault_o <= 1'b0;
        else if (!master_i) fault_o <= 1'b0;
        else if (!sel_s_i)  fault_o <= 1'b1;
    end

    assert_fault_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && !sel_s_i) |=> fault_o);
    assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |=> !fault_o);
    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && master_i) |=> fault_o);
endmodule

// File: rtl/spis_slave_core.sv
module spis_slave_core
    import spis_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              sel_n_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              master_mode_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              tx_load_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_done_o,
    output logic              mode_fault_o
);
    localparam int              CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    // synchronized pins
    logic [SIG_NUM-1:0] pins_s;
    logic               sck_s, sel_s, mosi_s;
    logic [1:0]         chg;

    spis_sync #(.WIDTH(SIG_NUM), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({mosi_i, sel_n_i, sck_i}),
        .q_o  (pins_s)
    );

    assign sck_s  = pins_s[SIG_SCK];
    assign sel_s  = pins_s[SIG_SEL];
    assign mosi_s = pins_s[SIG_MOSI];

    spis_edge #(.WIDTH(2), .RST_VAL(2'b10)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl_i({sel_s, sck_s}),
        .chg_o(chg)
    );

    // edge classification
    logic sck_rise, sck_fall, sel_fall;
    logic lead_ev, trail_ev, sample_ev, drive_ev;

    assign sck_rise  = chg[0] &  sck_s;
    assign sck_fall  = chg[0] & ~sck_s;
    assign sel_fall  = chg[1] & ~sel_s;
    assign lead_ev   = cpol_i ? sck_fall : sck_rise;
    assign trail_ev  = cpol_i ? sck_rise : sck_fall;
    assign sample_ev = cpha_i ? trail_ev : lead_ev;
    assign drive_ev  = cpha_i ? lead_ev  : trail_ev;

    // state machine
    spis_state_e state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] tx_hold_q, tx_sh_q, rx_sh_q;
    logic              last_bit;

    assign last_bit = sample_ev && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!master_mode_i && sel_fall) state_d = ST_SHIFT;            // START
            end
            ST_SHIFT: begin
                if (master_mode_i || sel_s)     state_d = ST_IDLE;             // ABORT
                else if (last_bit && !cpha_i)   state_d = ST_HOLD;             // FINISH
                else                            state_d = ST_SHIFT;            // WRAP / shifting
            end
            ST_HOLD: begin
                if (master_mode_i || sel_s)     state_d = ST_IDLE;             // RELEASE
            end
            default:                            state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            tx_hold_q <= '0;
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            rx_byte_o <= '0;
            rx_done_o <= 1'b0;
        end else begin
            rx_done_o <= 1'b0;
            if (tx_load_i) tx_hold_q <= tx_byte_i;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (state_d == ST_SHIFT) tx_sh_q <= tx_hold_q;
                end
                ST_SHIFT: begin
                    if (state_d == ST_IDLE) begin
                        cnt_q <= '0;
                    end else begin
                        if (sample_ev) begin
                            rx_sh_q <= {rx_sh_q[DATA_W-2:0], mosi_s};
                            cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                            if (cnt_q == LAST) begin
                                rx_byte_o <= {rx_sh_q[DATA_W-2:0], mosi_s};
                                rx_done_o <= 1'b1;
                            end
                        end
                        if (drive_ev) begin
                            if (cpha_i && cnt_q == '0) tx_sh_q <= tx_hold_q;
                            else                       tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_HOLD: begin
                    cnt_q <= '0;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign miso_oe_o = (state_q != ST_IDLE);
    assign miso_o    = miso_oe_o ? tx_sh_q[DATA_W-1] : 1'bz;

    spis_modefault i_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .master_i(master_mode_i),
        .sel_s_i (sel_s),
        .fault_o (mode_fault_o)
    );

    // checks next to the logic they guard
    assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (state_q == ST_IDLE));
    assert_master_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode_i |=> !miso_oe_o);
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |=> !rx_done_o);
    assert_done_from_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |-> ($past(state_q) == ST_SHIFT));
    assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (!rx_done_o && $stable(rx_byte_o)));
    assert_abort_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sel_s) |=> (!rx_done_o && state_q == ST_IDLE));
endmodule

// File: tb/test_spis_slave_core.sv
module test_spis_slave_core;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, sel_n = 1'b1;
    logic       cpol = 1'b0, cpha = 1'b0, master = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load = 1'b0;
    wire        miso;
    logic       miso_oe;
    logic [7:0] rx_byte;
    logic       rx_done;
    logic       fault;

    int n_chk = 0;
    int n_err = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spis_slave_core i_spis_slave_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_i        (sck),
        .mosi_i       (mosi),
        .sel_n_i      (sel_n),
        .cpol_i       (cpol),
        .cpha_i       (cpha),
        .master_mode_i(master),
        .tx_byte_i    (tx_byte),
        .tx_load_i    (tx_load),
        .miso_o       (miso),
        .miso_oe_o    (miso_oe),
        .rx_byte_o    (rx_byte),
        .rx_done_o    (rx_done),
        .mode_fault_o (fault)
    );

    always @(negedge clk) if (rst_n && rx_done) done_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // reference: bit i of the frame (0 = first on the wire) is the MSB side
    function automatic logic wire_bit(input logic [7:0] b, input int i);
        return b[7 - i];
    endfunction

    function automatic logic [7:0] expect_rx(input logic [7:0] sent);
        logic [7:0] r = '0;
        for (int i = 0; i < 8; i++) r = {r[6:0], wire_bit(sent, i)};
        return r;
    endfunction

    task automatic load_tx(input logic [7:0] b);
        tx_byte = b; tx_load = 1'b1;
        wait_clk(1);
        tx_load = 1'b0;
        wait_clk(1);
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cpol = pol; cpha = pha; sck = pol;
        wait_clk(HALF);
    endtask

    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
        for (int i = 0; i < 8; i++) begin
            if (!cpha) begin
                mosi = wire_bit(mo, i);
                wait_clk(HALF);
                mi[7-i] = miso;
                sck = ~cpol;
                wait_clk(HALF);
                sck = cpol;
            end else begin
                sck = ~cpol;
                wait_clk(HALF);
                mosi = wire_bit(mo, i);
                mi[7-i] = miso;
                wait_clk(HALF);
                sck = cpol;
                wait_clk(HALF);
            end
        end
        wait_clk(HALF);
    endtask

    // one phase-0 frame: select, one byte, release
    task automatic frame_pha0(input logic [7:0] txb, input logic [7:0] mob, input string req);
        logic [7:0] got;
        int d0;
        load_tx(txb);
        d0 = done_cnt;
        sel_n = 1'b0;
        xfer(mob, got);
        check({req, " R2 miso byte"}, got, txb);
        check({req, " R5 rx byte"}, rx_byte, expect_rx(mob));
        check({req, " R5 one pulse"}, done_cnt - d0, 1);
        sel_n = 1'b1;
        wait_clk(HALF);
    endtask

    // phase-1 burst under one select
    task automatic burst_pha1(input int nb, input logic [7:0] seed_b, input string req);
        logic [7:0] got, txb, mob;
        int d0;
        d0 = done_cnt;
        txb = seed_b ^ 8'h5A;
        load_tx(txb);
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < nb; k++) begin
            mob = seed_b + 8'(k * 37);
            xfer(mob, got);
            check({req, " R4 miso byte"}, got, txb);
            check({req, " R5 rx byte"}, rx_byte, expect_rx(mob));
            txb = txb + 8'h13;
            load_tx(txb);
        end
        check({req, " R4 pulse count"}, done_cnt - d0, nb);
        sel_n = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run hung actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [7:0] got;
        int d0;
        logic [7:0] held;
        int unsigned seed_v;
        seed_v = $urandom(32'hC0FFEE);

        wait_clk(4);
        // R10 reset state
        check("R10 miso hi-z", 32'(miso === 1'bz), 1);
        check("R10 rx_done", rx_done, 0);
        check("R10 fault", fault, 0);
        check("R10 rx_byte", rx_byte, 0);
        rst_n = 1'b1;
        wait_clk(HALF);

        // R1 and R2: MSB visible right after select falls, before any clock edge
        set_mode(1'b0, 1'b0);
        load_tx(8'hA5);
        check("R1 hi-z when deselected", 32'(miso === 1'bz), 1);
        sel_n = 1'b0;
        wait_clk(HALF);
        check("R1 driven when selected", miso_oe, 1);
        check("R2 MSB before first edge", 32'(miso), 1);
        sel_n = 1'b1;
        wait_clk(HALF);
        check("R1 released", 32'(miso === 1'bz), 1);

        // R5/R6 all four modes, directed values
        set_mode(1'b0, 1'b0); frame_pha0(8'h3C, 8'hC3, "R6 pol0");
        set_mode(1'b1, 1'b0); frame_pha0(8'h81, 8'h7E, "R6 pol1");
        set_mode(1'b0, 1'b1); burst_pha1(1, 8'h01, "R6 pol0 pha1");
        set_mode(1'b1, 1'b1); burst_pha1(3, 8'hF0, "R6 pol1 pha1");

        // R3: phase 0 ignores a second byte without a select toggle
        set_mode(1'b0, 1'b0);
        load_tx(8'h55);
        d0 = done_cnt;
        sel_n = 1'b0;
        xfer(8'h96, got);
        held = rx_byte;
        xfer(8'h69, got);
        check("R3 no extra pulse", done_cnt - d0, 1);
        check("R3 rx byte kept", rx_byte, held);
        check("R3 first byte value", held, expect_rx(8'h96));
        sel_n = 1'b1;
        wait_clk(HALF);
        frame_pha0(8'h0F, 8'hE1, "R3 after toggle");

        // R7: partial byte discarded
        set_mode(1'b1, 1'b0);
        load_tx(8'hFF);
        d0 = done_cnt;
        held = rx_byte;
        sel_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1; wait_clk(HALF);
            sck = ~cpol; wait_clk(HALF);
            sck = cpol;
        end
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(HALF);
        check("R7 no pulse on abort", done_cnt - d0, 0);
        check("R7 rx byte unchanged", rx_byte, held);
        frame_pha0(8'h24, 8'h42, "R7 next byte");

        // R8: most recent load wins
        set_mode(1'b0, 1'b1);
        load_tx(8'h11);
        load_tx(8'h96);
        sel_n = 1'b0;
        wait_clk(HALF);
        xfer(8'h00, got);
        check("R8 latest load used", got, 8'h96);
        sel_n = 1'b1;
        wait_clk(HALF);

        // R9: mode fault
        master = 1'b1;
        wait_clk(HALF);
        check("R9 no fault while select high", fault, 0);
        sel_n = 1'b0;
        wait_clk(HALF);
        check("R9 fault set", fault, 1);
        check("R1 master keeps miso hi-z", 32'(miso === 1'bz), 1);
        sel_n = 1'b1;
        wait_clk(HALF);
        check("R9 fault sticky", fault, 1);
        master = 1'b0;
        wait_clk(HALF);
        check("R9 fault cleared", fault, 0);

        // random mix of modes and data
        for (int f = 0; f < 40; f++) begin
            logic p0, p1;
            logic [7:0] a, b;
            p0 = 1'($urandom);
            p1 = 1'($urandom);
            a = 8'($urandom);
            b = 8'($urandom);
            set_mode(p0, p1);
            if (!p1) frame_pha0(a, b, "R5 random");
            else     burst_pha1(1 + int'($urandom % 3), b, "R4 random");
        end

        report();
    end
endmodule